// File: doc/BRIEF.md
# Power-Stage Fault and Shutdown Sequencer

This block supervises a switching audio power stage from the digital side. It watches an active-low shutdown request, a raw short-circuit flag from an analog detector and a die-temperature code in whole degrees Celsius. From these it drives an output-enable line, a mute line, the current state and two fault flags. It does not detect shorts, measure temperature or drive gates. It only decides when the power stage may switch.

The two faults are handled in different ways. A short-circuit is latched. It holds the stage off until the shutdown request is driven low and then released. If the short is still there afterwards, it trips again. An over-temperature fault clears itself: once the die has cooled by the hysteresis margin, the block restarts. Every exit from shutdown or from a thermal fault passes through a start-up wait before the outputs are enabled. The wait lasts a fixed number of cycles plus a programmable number that stands for the bypass-capacitor ramp.

The shutdown and short inputs are asynchronous and pass through two-flop synchronizers. The temperature code is expected to be synchronous to `clk`. The start-up and deglitch settings are expected to be held static while the block is out of shutdown.

Top module: `amp_guard_ctrl`

## Requirements
- R1: During and right after reset, `state_o` is OFF (code 0), `out_en_o` is 0, `mute_o` is 1 and `flags_o` is 0.
- R2: Three clock edges after `shdn_n_i` goes low, the state is OFF (0), `out_en_o` is 0 and `mute_o` is 1. While the state is OFF, the short input and the temperature cannot set the short latch (`flags_o[0]`).
- R3: Three edges after `shdn_n_i` rises, the state is STARTUP (1). The block then stays in STARTUP for exactly `FIXED_CNT + bypass_i` cycles before it enters RUN (2). `out_en_o` is 1 and `mute_o` is 0 only in RUN.
- R4: A qualified short drops `out_en_o` and enters SHORT_LATCHED (3) at the next edge. With `deglitch_i = 0`, that edge is the third edge after `short_i` rises.
- R5: The short latch (`flags_o[0]`) and the SHORT_LATCHED state persist after `short_i` falls. They are cleared only by a low level on the synchronized shutdown input, after which a release restarts normally.
- R6: If `short_i` is still high when shutdown is released, the block enters SHORT_LATCHED (3) three edges after the release instead of STARTUP.
- R7: A short is qualified only after the synchronized flag has been high for `deglitch_i + 1` consecutive cycles. Shorter pulses have no effect on any output.
- R8: A temperature code above `TRIP_C` (150) sets `flags_o[1]`. One edge later the state is THERMAL (4) with outputs off. A code of exactly 150 does not trip.
- R9: The thermal flag clears only when the code is at or below `TRIP_C - HYST_C` (135). Codes from 136 to 150 keep the fault.
- R10: When the thermal fault clears, the block re-enters STARTUP one edge later and waits the full start-up interval before RUN.
- R11: Priority runs shutdown, then short, then thermal, then start-up. A short and a thermal trip arriving in the same cycle give SHORT_LATCHED, not THERMAL.
- R12: A fault during STARTUP aborts it. The next start-up counts its full interval from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n_i | input | 1 | Asynchronous shutdown request, low means shut down |
| short_i | input | 1 | Asynchronous raw short-circuit flag, high means short |
| temp_i | input | TEMP_W | Die temperature code in degrees C, synchronous |
| deglitch_i | input | DG_W | Extra cycles a short must persist before it is accepted |
| bypass_i | input | PROG_W | Programmable part of the start-up wait, in cycles |
| out_en_o | output | 1 | Power-stage enable, high only in RUN |
| mute_o | output | 1 | Mute, high in every state except RUN |
| state_o | output | 3 | 0 OFF, 1 STARTUP, 2 RUN, 3 SHORT_LATCHED, 4 THERMAL |
| flags_o | output | 2 | Bit 0 short latch, bit 1 thermal fault |

## Verification
The two functions that can fall in the same cycle are the short qualifier and the thermal trip. The bench raises `short_i` one cycle before it raises the temperature above 150. This offset makes both reach the state logic on the same edge once the synchronizer delay is counted. The state must go straight from RUN to SHORT_LATCHED and never pass through THERMAL, and both flag bits must read 1. Shutdown is then asserted while both faults are still present. This shows that shutdown overrides both, clears the short latch and leaves the thermal flag untouched.

// File: rtl/ag_pkg.sv
package ag_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_START = 3'd1,
    ST_RUN   = 3'd2,
    ST_SHORT = 3'd3,
    ST_HOT   = 3'd4
  } ag_state_e;
endpackage

// File: rtl/ag_sync.sv
// Two-flop synchronizer bank; all bits reset to zero.
module ag_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ag_deglitch.sv
// Accepts the synchronized short flag only after it has been high for
// lim_i + 1 consecutive cycles.
module ag_deglitch #(
  parameter int DG_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flag_i,
  input  logic [DG_W-1:0] lim_i,
  output logic            qual_o
);
  logic [DG_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (!flag_i) begin
      run_q <= '0;
    end else if (run_q != {DG_W{1'b1}}) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign qual_o = flag_i && (run_q >= lim_i);

  // R7: a non-zero window can only open after the flag was already high
  p_qual_needs_history_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(qual_o) && (lim_i != '0)) |-> $past(flag_i));
endmodule

// File: rtl/ag_thermal.sv
// Over-temperature flag with hysteresis: sets above TRIP_C, clears at or
// below TRIP_C - HYST_C, holds in between.
module ag_thermal #(
  parameter int TEMP_W = 8,
  parameter int TRIP_C = 150,
  parameter int HYST_C = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] CLR_CODE  = TEMP_W'(TRIP_C - HYST_C);

  logic hot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q <= 1'b0;
    end else if (temp_i > TRIP_CODE) begin
      hot_q <= 1'b1;
    end else if (temp_i <= CLR_CODE) begin
      hot_q <= 1'b0;
    end
  end

  assign hot_o = hot_q;

  p_trip_above_limit_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(hot_q) |-> ($past(temp_i) > TRIP_CODE));

  p_clear_after_cooling_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(hot_q) |-> ($past(temp_i) <= CLR_CODE));
endmodule

// File: rtl/ag_seq.sv
// Prioritised state sequencer with start-up timer and short latch.
module ag_seq
  import ag_pkg::*;
#(
  parameter int FIXED_CNT = 410000,
  parameter int PROG_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_req_i,
  input  logic              short_qual_i,
  input  logic              hot_i,
  input  logic [PROG_W-1:0] bypass_i,
  output ag_state_e         state_o,
  output logic              out_en_o,
  output logic              mute_o,
  output logic              short_lat_o
);
  localparam int CNT_W = $clog2(FIXED_CNT + (1 << PROG_W)) + 1;

  ag_state_e        state_q, nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] total;
  logic             lat_q;
  logic             en_q, mute_q;

  assign total = CNT_W'(FIXED_CNT) + CNT_W'(bypass_i);

  always_comb begin
    nxt     = state_q;
    cnt_nxt = '0;
    if (!run_req_i) begin
      nxt = ST_OFF;
    end else if (lat_q || short_qual_i) begin
      nxt = ST_SHORT;
    end else if (hot_i) begin
      nxt = ST_HOT;
    end else begin
      case (state_q)
        ST_START: begin
          if (cnt_q == total - 1'b1) begin
            nxt = ST_RUN;
          end else begin
            nxt     = ST_START;
            cnt_nxt = cnt_q + 1'b1;
          end
        end
        ST_RUN:  nxt = ST_RUN;
        default: nxt = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      lat_q   <= 1'b0;
      en_q    <= 1'b0;
      mute_q  <= 1'b1;
    end else begin
      state_q <= nxt;
      cnt_q   <= cnt_nxt;
      lat_q   <= run_req_i && (lat_q || short_qual_i);
      en_q    <= (nxt == ST_RUN);
      mute_q  <= (nxt != ST_RUN);
    end
  end

  assign state_o     = state_q;
  assign out_en_o    = en_q;
  assign mute_o      = mute_q;
  assign short_lat_o = lat_q;

  // R3: the outputs only come up out of a start-up wait
  p_enable_after_startup_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> ($past(state_q) == ST_START));

  // R5: the latch only releases under a shutdown request
  p_latch_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(lat_q) |-> $past(!run_req_i));

  // R12: a faulted start-up leaves no residue in the timer
  p_timer_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_START) |-> (cnt_q == '0));
endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl
  import ag_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int TRIP_C    = 150,
  parameter int HYST_C    = 15,
  parameter int DG_W      = 4,
  parameter int PROG_W    = 8,
  parameter int FIXED_CNT = 410000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shdn_n_i,
  input  logic              short_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [DG_W-1:0]   deglitch_i,
  input  logic [PROG_W-1:0] bypass_i,
  output logic              out_en_o,
  output logic              mute_o,
  output logic [2:0]        state_o,
  output logic [1:0]        flags_o
);
  logic [1:0] raw_in, sync_out;
  logic       run_req, short_s, short_qual, hot;
  logic       short_lat;
  ag_state_e  st;

  assign raw_in  = {short_i, shdn_n_i};
  assign run_req = sync_out[0];
  assign short_s = sync_out[1];

  ag_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_out)
  );

  ag_deglitch #(.DG_W(DG_W)) u_dgl (
    .clk    (clk),
    .rst    (rst),
    .flag_i (short_s),
    .lim_i  (deglitch_i),
    .qual_o (short_qual)
  );

  ag_thermal #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_therm (
    .clk    (clk),
    .rst    (rst),
    .temp_i (temp_i),
    .hot_o  (hot)
  );

  ag_seq #(.FIXED_CNT(FIXED_CNT), .PROG_W(PROG_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .run_req_i    (run_req),
    .short_qual_i (short_qual),
    .hot_i        (hot),
    .bypass_i     (bypass_i),
    .state_o      (st),
    .out_en_o     (out_en_o),
    .mute_o       (mute_o),
    .short_lat_o  (short_lat)
  );

  assign state_o = st;
  assign flags_o = {hot, short_lat};

  p_shutdown_forces_off_r2: assert property (@(posedge clk) disable iff (rst)
    !run_req |=> ((state_o == ST_OFF) && !out_en_o && mute_o));

  p_short_kills_enable_r4: assert property (@(posedge clk) disable iff (rst)
    (run_req && short_qual) |=> (!out_en_o && (state_o == ST_SHORT)));

  p_hot_kills_enable_r8: assert property (@(posedge clk) disable iff (rst)
    (run_req && hot) |=> !out_en_o);

  // R11: short outranks thermal in the same cycle
  p_short_over_hot_r11: assert property (@(posedge clk) disable iff (rst)
    (run_req && short_qual && hot) |=> (state_o == ST_SHORT));
endmodule

// File: tb/amp_guard_ctrl_tb.sv
module amp_guard_ctrl_tb;
  localparam int FIX = 16;
  localparam int BYP = 4;
  localparam int TOT = FIX + BYP;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shdn_n = 1'b0;
  logic       short_r = 1'b0;
  logic [7:0] temp = 8'd25;
  logic [3:0] dgl = 4'd0;
  logic [7:0] byp = 8'(BYP);
  logic       out_en, mute;
  logic [2:0] state;
  logic [1:0] flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  amp_guard_ctrl #(.FIXED_CNT(FIX)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .shdn_n_i   (shdn_n),
    .short_i    (short_r),
    .temp_i     (temp),
    .deglitch_i (dgl),
    .bypass_i   (byp),
    .out_en_o   (out_en),
    .mute_o     (mute),
    .state_o    (state),
    .flags_o    (flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_state(input string req);
    chk(req, state, 2);
    chk(req, out_en, 1);
    chk(req, mute, 0);
  endtask

  // shutdown then release, ending in RUN
  task automatic cycle_shutdown();
    shdn_n = 1'b0;
    step(3);
    chk("R2 off state", state, 0);
    chk("R2 off enable", out_en, 0);
    shdn_n = 1'b1;
    step(TOT + 3);
    run_state("R5 restart");
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 state", state, 0);
    chk("R1 enable", out_en, 0);
    chk("R1 mute", mute, 1);
    chk("R1 flags", flags, 0);
    rst = 1'b0;
    step(2);
    chk("R1 held off", state, 0);
  endtask

  task automatic t_startup();
    shdn_n = 1'b1;
    step(2);
    chk("R3 still off", state, 0);
    step(1);
    chk("R3 startup", state, 1);
    step(TOT - 1);
    chk("R3 last wait cycle", state, 1);
    chk("R3 enable during wait", out_en, 0);
    chk("R3 mute during wait", mute, 1);
    step(1);
    run_state("R3 run");
  endtask

  task automatic t_short_latch();
    short_r = 1'b1;
    step(2);
    chk("R4 before trip", out_en, 1);
    step(1);
    chk("R4 enable drop", out_en, 0);
    chk("R4 state", state, 3);
    chk("R5 flag", flags, 1);
    short_r = 1'b0;
    step(12);
    chk("R5 latched", state, 3);
    chk("R5 latched enable", out_en, 0);
    shdn_n = 1'b0;
    step(3);
    chk("R5 cleared flag", flags, 0);
    shdn_n = 1'b1;
    step(TOT + 3);
    run_state("R5 recovered");
  endtask

  task automatic t_retrip();
    short_r = 1'b1;
    step(3);
    chk("R6 first trip", state, 3);
    shdn_n = 1'b0;
    step(5);
    chk("R2 off with short", state, 0);
    chk("R2 latch ignored", flags, 0);
    shdn_n = 1'b1;
    step(3);
    chk("R6 retrip", state, 3);
    chk("R6 retrip enable", out_en, 0);
    short_r = 1'b0;
    cycle_shutdown();
  endtask

  task automatic t_deglitch();
    dgl = 4'd3;
    short_r = 1'b1;
    step(3);
    short_r = 1'b0;
    step(10);
    run_state("R7 short pulse ignored");
    chk("R7 no latch", flags, 0);
    short_r = 1'b1;
    step(5);
    chk("R7 within window", out_en, 1);
    step(1);
    chk("R7 accepted", out_en, 0);
    chk("R7 state", state, 3);
    short_r = 1'b0;
    dgl = 4'd0;
    cycle_shutdown();
  endtask

  task automatic t_thermal();
    temp = 8'd150;
    step(5);
    run_state("R8 boundary 150");
    chk("R8 no flag at 150", flags, 0);
    temp = 8'd151;
    step(1);
    chk("R8 flag", flags, 2);
    step(1);
    chk("R8 thermal state", state, 4);
    chk("R8 enable off", out_en, 0);
    chk("R8 mute on", mute, 1);
    temp = 8'd136;
    step(6);
    chk("R9 hold at 136", state, 4);
    temp = 8'd135;
    step(1);
    chk("R9 flag cleared", flags, 0);
    step(1);
    chk("R10 restart", state, 1);
    step(TOT - 1);
    chk("R10 full wait", state, 1);
    step(1);
    run_state("R10 run");
  endtask

  task automatic t_abort();
    shdn_n = 1'b0;
    step(3);
    shdn_n = 1'b1;
    step(3);
    chk("R12 startup", state, 1);
    step(5);
    temp = 8'd160;
    step(2);
    chk("R12 aborted", state, 4);
    temp = 8'd100;
    step(2);
    chk("R12 restart", state, 1);
    step(TOT - 1);
    chk("R12 counts from zero", state, 1);
    step(1);
    run_state("R12 run");
  endtask

  task automatic t_priority();
    short_r = 1'b1;
    step(1);
    temp = 8'd170;
    step(1);
    chk("R11 before both", state, 2);
    step(1);
    chk("R11 short wins", state, 3);
    chk("R11 both flags", flags, 3);
    shdn_n = 1'b0;
    step(3);
    chk("R11 shutdown wins", state, 0);
    chk("R11 latch cleared, thermal kept", flags, 2);
    short_r = 1'b0;
    temp = 8'd25;
    step(2);
    shdn_n = 1'b1;
    step(TOT + 3);
    run_state("R11 recovered");
  endtask

  initial begin
    step(1);
    t_reset();
    t_startup();
    t_short_latch();
    t_retrip();
    t_deglitch();
    t_thermal();
    t_abort();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule